// File: doc/BRIEF.md
# Ring-Chained FIFO Slice Token Controller

This block holds the control state for one slice of a deep FIFO that is built from several equal slices wired in a ring. Every slice sees the same write and read requests. Only the slice that holds the write token stores the incoming word, and only the slice that holds the read token supplies the outgoing word. When the write pointer of the owning slice reaches the top of its local storage, the slice gives the write token to the next slice in the ring. The read token moves on in the same way when the read pointer reaches the top. Both handovers travel on one pulse line per link. The storage array and the combining of per-slice flags into system flags are outside the block. The block supplies the write gate, the read gate and the two local addresses.

The operating mode is taken from strap inputs while reset is asserted. During reset every slice drives its link output high. A slice therefore sees its link input high during reset when it sits in a ring, and low when the link input is tied off. A slice with a tied-off link input and its head strap high runs standalone. A standalone slice always holds both tokens and never pulses its link output. In a ring, the slice whose head strap is low starts with both tokens and the other slices start with none.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: While reset is asserted, link_out is 1. In ring mode, on leaving reset, the slice with head_n=0 has wr_sel=1 and rd_sel=1, and every slice with head_n=1 has wr_sel=0 and rd_sel=0.
- R2: A slice that sees link_in=0 and head_n=1 during reset runs standalone (chain_mode=0). It keeps wr_sel=1 and rd_sel=1 and holds link_out=0 after reset, whatever link_in does.
- R3: wr_addr and rd_addr are 0 after reset. Each goes up by one on every cycle its gate is high, and goes from DEPTH-1 back to 0.
- R4: In ring mode, a write gated while wr_addr=DEPTH-1 drives link_out=1 in that same cycle, and wr_sel is 0 from the next cycle on.
- R5: In ring mode, a read gated while rd_addr=DEPTH-1 drives link_out=1 in that same cycle, and rd_sel is 0 from the next cycle on.
- R6: In ring mode, pulses on link_in hand over tokens in alternation. The first pulse after reset gives the write token, the next gives the read token, and so on. The token is held from the cycle after the pulse.
- R7: In a ring, at every cycle after reset, exactly one slice has wr_sel=1 and exactly one slice has rd_sel=1.
- R8: wr_en = wr_req AND wr_sel, and rd_en = rd_req AND rd_sel. A slice that does not hold a token ignores the matching request, and its address stays unchanged.
- R9: aux_en, which permits the half-full flag and the retransmit function, is 1 in standalone mode and 0 in ring mode.
- R10: A ring of slices sharing one set of requests returns words in the order they were written, across slice boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the strap-sampling window |
| head_n | input | 1 | Low marks the slice that starts with both tokens |
| link_in | input | 1 | Handover pulse from the previous slice |
| wr_req | input | 1 | Shared write request |
| rd_req | input | 1 | Shared read request |
| link_out | output | 1 | Handover pulse to the next slice; high during reset |
| wr_en | output | 1 | Local write gate to the storage |
| rd_en | output | 1 | Local read gate to the storage |
| wr_sel | output | 1 | Slice holds the write token |
| rd_sel | output | 1 | Slice holds the read token |
| wr_addr | output | AW | Local write address |
| rd_addr | output | AW | Local read address |
| chain_mode | output | 1 | 1 when ring mode was latched at reset |
| aux_en | output | 1 | Half-full and retransmit permitted |

## Verification
The assertions assume two things about the inputs. First, the ring never sees a write while all slices are full, and never sees a read while all slices are empty. Second, the pulse arriving on link_in comes from a neighbour that obeys the same rules. Together these mean that a slice never passes both tokens in the same cycle, and never receives a token it already holds. The bench keeps to these assumptions by tracking ring occupancy itself. It asserts a write only below the full count and a read only when words are present, so simultaneous reads and writes never meet at the same boundary.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // Meaning of the next pulse arriving on the link input.
  typedef enum logic {LINK_WR = 1'b0, LINK_RD = 1'b1} link_kind_t;

  function automatic link_kind_t flip_kind(input link_kind_t k);
    return (k == LINK_WR) ? LINK_RD : LINK_WR;
  endfunction
endpackage

// File: rtl/xfer_ptr.sv
module xfer_ptr #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign at_last = (addr == LAST);

  always_ff @(posedge clk) begin
    if (rst)          addr <= '0;
    else if (step)    addr <= at_last ? '0 : addr + 1'b1;
  end

  // R3: wrap from the top location to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    step && at_last |=> addr == '0);
  // R3: plain increment elsewhere
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    step && !at_last |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/token_cell.sv
module token_cell (
  input  logic clk,
  input  logic rst,
  input  logic start_own,
  input  logic take,
  input  logic give,
  output logic own
);
  always_ff @(posedge clk) begin
    if (rst)       own <= start_own;
    else if (give) own <= 1'b0;
    else if (take) own <= 1'b1;
  end

  // R6: a token only arrives at a slice that lacks it
  a_r6_take_free: assert property (@(posedge clk) disable iff (rst)
    take |-> !own);
  // R4_R5: a passed token is gone on the next cycle
  a_r4_r5_give_drop: assert property (@(posedge clk) disable iff (rst)
    give |=> !own);
endmodule

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_n,
  input  logic          link_in,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          link_out,
  output logic          wr_en,
  output logic          rd_en,
  output logic          wr_sel,
  output logic          rd_sel,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          chain_mode,
  output logic          aux_en
);
  logic       chain_q;
  link_kind_t expect_q;
  logic       wr_last, rd_last;
  logic       w_pass, r_pass;
  logic       take_w, take_r;
  logic       start_own;

  // Mode straps sampled throughout reset (R2, R9).
  always_ff @(posedge clk) begin
    if (rst) chain_q <= link_in | ~head_n;
  end

  // Only a ring member without the head strap starts empty-handed (R1).
  assign start_own = ~(link_in & head_n);

  // Gates (R8).
  assign wr_en = wr_req & wr_sel;
  assign rd_en = rd_req & rd_sel;

  // Handover out (R4, R5); held high in reset so neighbours detect the ring.
  assign w_pass   = chain_q & wr_en & wr_last;
  assign r_pass   = chain_q & rd_en & rd_last;
  assign link_out = rst | w_pass | r_pass;

  // Handover in: pulses alternate write, read, write ... (R6).
  always_ff @(posedge clk) begin
    if (rst)                    expect_q <= LINK_WR;
    else if (chain_q & link_in) expect_q <= flip_kind(expect_q);
  end

  assign take_w = chain_q & link_in & (expect_q == LINK_WR);
  assign take_r = chain_q & link_in & (expect_q == LINK_RD);

  token_cell u_wtok (
    .clk(clk), .rst(rst), .start_own(start_own),
    .take(take_w), .give(w_pass), .own(wr_sel)
  );

  token_cell u_rtok (
    .clk(clk), .rst(rst), .start_own(start_own),
    .take(take_r), .give(r_pass), .own(rd_sel)
  );

  xfer_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst(rst), .step(wr_en), .addr(wr_addr), .at_last(wr_last)
  );

  xfer_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst(rst), .step(rd_en), .addr(rd_addr), .at_last(rd_last)
  );

  assign chain_mode = chain_q;
  assign aux_en     = ~chain_q;

  // R2: standalone keeps both tokens and a silent link
  a_r2_solo_owns: assert property (@(posedge clk) disable iff (rst)
    !chain_q |-> wr_sel && rd_sel && !link_out);
  // R8: no token, no address movement
  a_r8_idle_wr: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(wr_addr));
  a_r8_idle_rd: assert property (@(posedge clk) disable iff (rst)
    !rd_sel |=> $stable(rd_addr));
  // R4: the two handovers never share one link cycle
  a_r4_one_pass: assert property (@(posedge clk) disable iff (rst)
    !(w_pass && r_pass));
endmodule

// File: tb/fifo_chain_ctrl_bench.sv
module fifo_chain_ctrl_bench;
  localparam int D = 4;
  localparam int N = 3;
  localparam int AW = 2;
  localparam int TOTAL = D * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [7:0] din = '0;
  logic [N-1:0] lo, wen, ren, wsel, rsel, cmode, aux;
  logic [AW-1:0] wa [N];
  logic [AW-1:0] ra [N];

  for (genvar i = 0; i < N; i++) begin : g_ring
    fifo_chain_ctrl #(.DEPTH(D)) u_fifo_chain_ctrl (
      .clk(clk), .rst(rst), .head_n(i != 0), .link_in(lo[(i + N - 1) % N]),
      .wr_req(wr_req), .rd_req(rd_req), .link_out(lo[i]),
      .wr_en(wen[i]), .rd_en(ren[i]), .wr_sel(wsel[i]), .rd_sel(rsel[i]),
      .wr_addr(wa[i]), .rd_addr(ra[i]), .chain_mode(cmode[i]), .aux_en(aux[i])
    );
  end

  logic s_wr = 1'b0, s_rd = 1'b0;
  logic s_lo, s_wen, s_ren, s_wsel, s_rsel, s_cm, s_aux;
  logic [AW-1:0] s_wa, s_ra;

  fifo_chain_ctrl #(.DEPTH(D)) u_fifo_chain_ctrl (
    .clk(clk), .rst(rst), .head_n(1'b1), .link_in(1'b0),
    .wr_req(s_wr), .rd_req(s_rd), .link_out(s_lo),
    .wr_en(s_wen), .rd_en(s_ren), .wr_sel(s_wsel), .rd_sel(s_rsel),
    .wr_addr(s_wa), .rd_addr(s_ra), .chain_mode(s_cm), .aux_en(s_aux)
  );

  // Storage model for the ring.
  logic [7:0] mem [N][D];
  always @(posedge clk) begin
    for (int i = 0; i < N; i++)
      if (wen[i]) mem[i][wa[i]] <= din;
  end

  int nchk = 0, nbad = 0, wcnt = 0, rcnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  // One ring cycle: drive, check gates and data, then check idle slices.
  task automatic cyc(input bit w, input bit r);
    int ws, rs;
    logic [AW-1:0] keep [N];
    @(negedge clk);
    wr_req = w; rd_req = r; din = pat(wcnt);
    #2;
    ws = (wcnt / D) % N;
    rs = (rcnt / D) % N;
    for (int i = 0; i < N; i++) begin
      keep[i] = wa[i];
      chk(wsel[i] == (i == ws), "R6/R7 write token", int'(wsel[i]), int'(i == ws));
      chk(rsel[i] == (i == rs), "R6/R7 read token", int'(rsel[i]), int'(i == rs));
      chk(wen[i] == (w && i == ws), "R8 write gate", int'(wen[i]), int'(w && i == ws));
      chk(ren[i] == (r && i == rs), "R8 read gate", int'(ren[i]), int'(r && i == rs));
      chk(lo[i] == ((w && i == ws && wcnt % D == D - 1) || (r && i == rs && rcnt % D == D - 1)),
          "R4/R5 link pulse", int'(lo[i]),
          int'((w && i == ws && wcnt % D == D - 1) || (r && i == rs && rcnt % D == D - 1)));
    end
    if (w) chk(int'(wa[ws]) == wcnt % D, "R3 write address", int'(wa[ws]), wcnt % D);
    if (r) begin
      chk(int'(ra[rs]) == rcnt % D, "R3 read address", int'(ra[rs]), rcnt % D);
      chk(mem[rs][ra[rs]] == pat(rcnt), "R10 word order", int'(mem[rs][ra[rs]]), int'(pat(rcnt)));
    end
    @(posedge clk);
    #2;
    for (int i = 0; i < N; i++)
      if (i != ws) chk(wa[i] == keep[i], "R8 idle address", int'(wa[i]), int'(keep[i]));
    if (w) wcnt++;
    if (r) rcnt++;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(lo[i] == 1'b1, "R1 link high in reset", int'(lo[i]), 1);
      chk(wsel[i] == (i == 0), "R1 start write token", int'(wsel[i]), int'(i == 0));
      chk(rsel[i] == (i == 0), "R1 start read token", int'(rsel[i]), int'(i == 0));
      chk(cmode[i] == 1'b1, "R9 ring mode", int'(cmode[i]), 1);
      chk(aux[i] == 1'b0, "R9 aux off in ring", int'(aux[i]), 0);
      chk(wa[i] == '0, "R3 reset address", int'(wa[i]), 0);
    end
    rst = 1'b0;
    #2;
    chk(lo == '0, "R1 link quiet after reset", int'(lo), 0);
  endtask

  task automatic t_fill_drain;
    for (int k = 0; k < 10; k++) cyc(1'b1, 1'b0);
    for (int k = 0; k < 10; k++) cyc(1'b0, 1'b1);
  endtask

  task automatic t_full_ring;
    while (wcnt - rcnt < TOTAL) cyc(1'b1, 1'b0);
    while (rcnt < wcnt) cyc(1'b0, 1'b1);
  endtask

  task automatic t_stream;
    for (int k = 0; k < 40; k++) cyc(wcnt - rcnt < TOTAL, rcnt < wcnt);
  endtask

  task automatic t_bursty;
    for (int k = 0; k < 60; k++)
      cyc((k % 5 < 3) && (wcnt - rcnt < TOTAL), (k % 5 >= 2) && (rcnt < wcnt));
    while (rcnt < wcnt) cyc(1'b0, 1'b1);
  endtask

  task automatic t_solo;
    chk(s_cm == 1'b0, "R2 standalone mode", int'(s_cm), 0);
    chk(s_aux == 1'b1, "R9 aux on standalone", int'(s_aux), 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); s_wr = 1'b1; s_rd = 1'b0;
      #2;
      chk(s_wen && s_wsel && s_rsel, "R2 standalone owns", int'(s_wen), 1);
      chk(s_lo == 1'b0, "R2 standalone link quiet", int'(s_lo), 0);
      chk(int'(s_wa) == k % D, "R3 standalone write wrap", int'(s_wa), k % D);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); s_wr = 1'b0; s_rd = 1'b1;
      #2;
      chk(s_ren == 1'b1, "R2 standalone read gate", int'(s_ren), 1);
      chk(s_lo == 1'b0, "R2 standalone link quiet", int'(s_lo), 0);
      chk(int'(s_ra) == k % D, "R3 standalone read wrap", int'(s_ra), k % D);
    end
    @(negedge clk); s_rd = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_fill_drain();
    t_full_ring();
    t_stream();
    t_bursty();
    t_solo();
    @(negedge clk); wr_req = 1'b0; rd_req = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule